// File: doc/BRIEF.md
# Execute Stage with Parked Line Load

This block is the single-issue execute stage of a small in-order 64-bit pipeline. It receives instructions whose two operands have already been read from the register file. For plain arithmetic it forms the sum of the operands. For the two conditional absolute jumps it picks either the first operand or the instruction's sequential next-PC, depending on whether the second operand is zero. Every non-load result leaves for writeback in the same cycle the instruction is accepted. The path from input to writeback is combinational, and no register sits on it.

A load is split into two phases. When it is accepted, the stage issues a read command for the memory line that holds the effective address (operand sum) and parks the load in a one-entry stall slot. Nothing goes to writeback in that cycle. While the slot is occupied, the stage accepts no new instruction. When the memory returns the whole line and writeback can take a result, the stage selects eight consecutive bytes at the address's in-line offset, assembles them little-endian, and retires the load. Each interface is a valid/ready pair. The stage takes a new instruction only when both the writeback output and the memory command output are ready, so neither destination can refuse a result that has already been committed.

Top module: `exec_unit`

## Requirements
- R1: After reset the stall slot is empty: with no input valid, `wbValid`, `memCmdValid` and `memRspReady` are 0, and `inReady` is 1 when `wbReady` and `memCmdReady` are both 1.
- R2: Opcode encoding: 0 = add, 1 = emit, 2 = jump-if-zero, 3 = jump-if-nonzero, 4 = load. Add, emit and every undefined opcode (5 to 15) produce `inOpA + inOpB` modulo 2^64 on `wbResult`.
- R3: Jump-if-zero produces `inOpA` when `inOpB == 0` and `inNextPc` otherwise. Jump-if-nonzero produces `inOpA` when `inOpB != 0` and `inNextPc` otherwise.
- R4: A load is accepted in the same cycle that its command handshake completes. The command carries `memCmdLine = (inOpA + inOpB) >> 6` with `memCmdWrite = 0`, and `wbValid` stays 0 in that cycle.
- R5: While a load is parked, `inReady` and `memCmdValid` are 0, whatever the other inputs are.
- R6: A parked load drives `wbValid` equal to `memRspValid` and `memRspReady` equal to `wbReady`. It retires (the slot frees) only in a cycle where both `memRspValid` and `wbReady` are 1.
- R7: The load result is bytes `k..k+7` of `memRspData`, where byte j occupies bits `8j+7:8j` and `k` is bits 5:0 of the effective address. Byte `k` lands in bits 7:0 of `wbResult`.
- R8: With the slot empty, `inReady = wbReady & memCmdReady`. A non-load presents `wbValid = inValid & memCmdReady`, and a load presents `memCmdValid = inValid & wbReady`.
- R9: `wbOpcode`, `wbNextPc` and `wbGen` equal the instruction's opcode, next-PC and generation tag unchanged, for loads as well as non-loads.
- R10: With no load parked, `memRspReady` is 0, so a response that arrives then is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming instruction valid |
| inReady | output | 1 | Stage accepts the incoming instruction |
| inOpcode | input | 4 | Operation code |
| inOpA | input | 64 | First operand value |
| inOpB | input | 64 | Second operand value |
| inNextPc | input | 64 | Sequential next-PC of the instruction |
| inGen | input | 4 | Generation tag |
| wbValid | output | 1 | Result to writeback valid |
| wbReady | input | 1 | Writeback can accept |
| wbOpcode | output | 4 | Opcode of the result |
| wbResult | output | 64 | Computed or loaded value |
| wbNextPc | output | 64 | Next-PC carried through |
| wbGen | output | 4 | Generation tag carried through |
| memCmdValid | output | 1 | Line read command valid |
| memCmdReady | input | 1 | Memory accepts a command |
| memCmdLine | output | 58 | Line address (byte address >> 6) |
| memCmdWrite | output | 1 | Write flag, always 0 here |
| memRspValid | input | 1 | Returned line valid |
| memRspReady | output | 1 | Stage consumes the returned line |
| memRspData | input | 512 | Returned 64-byte line, byte 0 in bits 7:0 |

## Verification
The bench targets the parked-load window. It holds a competing instruction at the input during that window to catch a design that lets it slip past the load and reorders writeback. It also withholds `wbReady` while the response is present, which exposes a design that consumes the line early and loses the result. Loads at offsets 0, 56 and an unaligned 5, plus effective addresses formed with a carry out of the low six bits, show whether bytes are taken from the wrong place or in the wrong order. Jumps with a zero and a non-zero condition operand, a refused command while writeback is ready, and a load offered while writeback is stalled each expose a swapped condition or a stage that commits to one destination without the other.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 4'd0,
    OPC_EMIT = 4'd1,
    OPC_JZ   = 4'd2,
    OPC_JNZ  = 4'd3,
    OPC_LOAD = 4'd4
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureLoad;  // park the accepted load this cycle
    logic retireLoad;   // parked load leaves this cycle
    logic selSlot;      // writeback fields come from the stall slot
  } ctlStrobes_t;

endpackage

// File: rtl/exec_unit_pick.sv
// Byte-wise little-endian word selection out of a memory line.
module exec_unit_pick #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8
) (
  input  logic [LINE_W-1:0] lineData,
  input  logic [OFS_W-1:0]  byteOfs,
  output logic [WORD_W-1:0] word
);

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    logic [OFS_W-1:0] idx;
    assign idx = byteOfs + OFS_W'(k);
    assign word[8*k +: 8] = lineData[{idx, 3'b000} +: 8];
  end

endmodule

// File: rtl/exec_unit_ctl.sv
// Stall-slot control: acceptance, command issue, retirement.
module exec_unit_ctl
  import exec_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isLoad,
  input  logic        wbReady,
  input  logic        memCmdReady,
  input  logic        memRspValid,
  output logic        inReady,
  output logic        wbValid,
  output logic        memCmdValid,
  output logic        memRspReady,
  output ctlStrobes_t strobes
);

  logic slotFull;
  logic accOk;
  logic fire;
  logic retire;

  assign accOk       = !slotFull && wbReady && memCmdReady;
  assign inReady     = accOk;
  assign fire        = inValid && accOk;
  assign memCmdValid = !slotFull && inValid && isLoad && wbReady;
  assign wbValid     = slotFull ? memRspValid : (inValid && !isLoad && memCmdReady);
  assign memRspReady = slotFull && wbReady;
  assign retire      = slotFull && memRspValid && wbReady;

  always_comb begin
    strobes             = '0;
    strobes.captureLoad = fire && isLoad;
    strobes.retireLoad  = retire;
    strobes.selSlot     = slotFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    slotFull <= 1'b0;
    else if (fire && isLoad)      slotFull <= 1'b1;
    else if (retire)              slotFull <= 1'b0;
  end

  // R5: a parked load blocks acceptance and command issue
  assert_no_accept_parked_R5: assert property (@(posedge clk) disable iff (!rstN)
    slotFull |-> (!inReady && !memCmdValid));

  // R8: acceptance requires both downstream readies
  assert_accept_both_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (wbReady && memCmdReady));

  // R4: a command cycle never forwards to writeback
  assert_cmd_not_wb_R4: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> !wbValid);

  // R6: parked load stays until response and writeback meet
  assert_park_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotFull && !(memRspValid && wbReady)) |=> slotFull);

  // R6: slot freed only after a completed response handshake
  assert_free_after_rsp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slotFull) |-> $past(memRspValid && memRspReady && wbValid));

  // R10: line consumed only alongside a writeback offer
  assert_rsp_with_wb_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRspReady |-> (wbValid || !memRspValid));

endmodule

// File: rtl/exec_unit_dp.sv
// Datapath: arithmetic, jump selection, line address, stall slot storage.
module exec_unit_dp
  import exec_unit_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int LINE_BYTES = 64,
  parameter int GEN_W      = 4,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int LADDR_W   = XLEN - OFS_W,
  localparam int WORD_BYTES = XLEN / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   inOpcode,
  input  logic [XLEN-1:0]    inOpA,
  input  logic [XLEN-1:0]    inOpB,
  input  logic [XLEN-1:0]    inNextPc,
  input  logic [GEN_W-1:0]   inGen,
  input  logic [LINE_W-1:0]  memRspData,
  input  ctlStrobes_t        strobes,
  output logic               isLoad,
  output logic [OPC_W-1:0]   wbOpcode,
  output logic [XLEN-1:0]    wbResult,
  output logic [XLEN-1:0]    wbNextPc,
  output logic [GEN_W-1:0]   wbGen,
  output logic [LADDR_W-1:0] memCmdLine
);

  logic [XLEN-1:0]  sum;
  logic [XLEN-1:0]  aluResult;
  logic [XLEN-1:0]  pickedWord;
  logic [OPC_W-1:0] slotOp;
  logic [XLEN-1:0]  slotNextPc;
  logic [GEN_W-1:0] slotGen;
  logic [OFS_W-1:0] slotOfs;

  assign sum        = inOpA + inOpB;
  assign isLoad     = (inOpcode == OPC_LOAD);
  assign memCmdLine = sum[XLEN-1:OFS_W];

  always_comb begin
    unique case (inOpcode)
      OPC_JZ:  aluResult = (inOpB == '0) ? inOpA : inNextPc;
      OPC_JNZ: aluResult = (inOpB != '0) ? inOpA : inNextPc;
      default: aluResult = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotOp     <= '0;
      slotNextPc <= '0;
      slotGen    <= '0;
      slotOfs    <= '0;
    end else if (strobes.captureLoad) begin
      slotOp     <= inOpcode;
      slotNextPc <= inNextPc;
      slotGen    <= inGen;
      slotOfs    <= sum[OFS_W-1:0];
    end
  end

  exec_unit_pick #(
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) pick_i (
    .lineData (memRspData),
    .byteOfs  (slotOfs),
    .word     (pickedWord)
  );

  assign wbOpcode = strobes.selSlot ? slotOp     : inOpcode;
  assign wbNextPc = strobes.selSlot ? slotNextPc : inNextPc;
  assign wbGen    = strobes.selSlot ? slotGen    : inGen;
  assign wbResult = strobes.selSlot ? pickedWord : aluResult;

  // R9: parked metadata does not drift while waiting
  assert_slot_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selSlot && !strobes.retireLoad) |=>
      ($stable(slotGen) && $stable(slotNextPc) && $stable(slotOfs)));

  // R4: capture happens only for a load opcode
  assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureLoad |-> isLoad);

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_unit_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int LINE_BYTES = 64,
  parameter int GEN_W      = 4,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int LADDR_W   = XLEN - OFS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [OPC_W-1:0]   inOpcode,
  input  logic [XLEN-1:0]    inOpA,
  input  logic [XLEN-1:0]    inOpB,
  input  logic [XLEN-1:0]    inNextPc,
  input  logic [GEN_W-1:0]   inGen,
  output logic               wbValid,
  input  logic               wbReady,
  output logic [OPC_W-1:0]   wbOpcode,
  output logic [XLEN-1:0]    wbResult,
  output logic [XLEN-1:0]    wbNextPc,
  output logic [GEN_W-1:0]   wbGen,
  output logic               memCmdValid,
  input  logic               memCmdReady,
  output logic [LADDR_W-1:0] memCmdLine,
  output logic               memCmdWrite,
  input  logic               memRspValid,
  output logic               memRspReady,
  input  logic [LINE_W-1:0]  memRspData
);

  ctlStrobes_t strobes;
  logic        isLoad;

  assign memCmdWrite = 1'b0;

  exec_unit_ctl ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .isLoad      (isLoad),
    .wbReady     (wbReady),
    .memCmdReady (memCmdReady),
    .memRspValid (memRspValid),
    .inReady     (inReady),
    .wbValid     (wbValid),
    .memCmdValid (memCmdValid),
    .memRspReady (memRspReady),
    .strobes     (strobes)
  );

  exec_unit_dp #(
    .XLEN       (XLEN),
    .LINE_BYTES (LINE_BYTES),
    .GEN_W      (GEN_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .inOpcode   (inOpcode),
    .inOpA      (inOpA),
    .inOpB      (inOpB),
    .inNextPc   (inNextPc),
    .inGen      (inGen),
    .memRspData (memRspData),
    .strobes    (strobes),
    .isLoad     (isLoad),
    .wbOpcode   (wbOpcode),
    .wbResult   (wbResult),
    .wbNextPc   (wbNextPc),
    .wbGen      (wbGen),
    .memCmdLine (memCmdLine)
  );

endmodule

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid, inReady;
  logic [3:0]   inOpcode;
  logic [63:0]  inOpA, inOpB, inNextPc;
  logic [3:0]   inGen;
  logic         wbValid, wbReady;
  logic [3:0]   wbOpcode;
  logic [63:0]  wbResult, wbNextPc;
  logic [3:0]   wbGen;
  logic         memCmdValid, memCmdReady;
  logic [57:0]  memCmdLine;
  logic         memCmdWrite;
  logic         memRspValid, memRspReady;
  logic [511:0] memRspData;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  exec_unit dut_i (.*);

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] expAlu(input logic [3:0] op, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] npc);
    if (op == 4'd2) return (b == 64'd0) ? a : npc;
    if (op == 4'd3) return (b != 64'd0) ? a : npc;
    return a + b;
  endfunction

  function automatic logic [63:0] expWord(input logic [511:0] line, input int ofs);
    logic [63:0] w = '0;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = line[8*((ofs + i) % 64) +: 8];
    return w;
  endfunction

  function automatic logic [511:0] rndLine();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[32*i +: 32] = $urandom();
    return l;
  endfunction

  task automatic idle();
    inValid = 0; inOpcode = 0; inOpA = 0; inOpB = 0; inNextPc = 0; inGen = 0;
    wbReady = 1; memCmdReady = 1; memRspValid = 0; memRspData = '0;
  endtask

  task automatic setInst(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] npc, input logic [3:0] gen);
    inValid = 1; inOpcode = op; inOpA = a; inOpB = b; inNextPc = npc; inGen = gen;
  endtask

  // one non-load instruction offered with both readies high, checked at the ports
  task automatic aluOne(input string req, input logic [3:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] npc);
    @(negedge clk);
    idle();
    setInst(op, a, b, npc, 4'd7);
    #1;
    chk({req, " wbValid"}, wbValid, 1'b1);
    chk({req, " result"}, wbResult, expAlu(op, a, b, npc));
  endtask

  // full load: command, parked wait, backpressured response, retire, release
  task automatic doLoad(input int ofs, input int waitCyc, input int bpCyc);
    logic [63:0] a, b, npc, addr;
    logic [3:0]  gen;
    logic [511:0] line;
    a    = rnd64();
    addr = (rnd64() & ~64'h3F) | 64'(ofs);
    b    = addr - a;
    npc  = rnd64();
    gen  = 4'($urandom());
    line = rndLine();

    @(negedge clk);
    idle();
    setInst(4'd4, a, b, npc, gen);
    #1;
    chk("R4 cmd valid", memCmdValid, 1'b1);
    chk("R4 cmd line", memCmdLine, addr[63:6]);
    chk("R4 cmd write", memCmdWrite, 1'b0);
    chk("R4 no wb in cmd cycle", wbValid, 1'b0);
    chk("R8 load accepted", inReady, 1'b1);

    for (int i = 0; i < waitCyc; i++) begin
      @(negedge clk);
      setInst(4'd0, rnd64(), rnd64(), rnd64(), 4'd1);
      wbReady = 1'($urandom()); memCmdReady = 1'($urandom()); memRspValid = 0;
      #1;
      chk("R5 inReady parked", inReady, 1'b0);
      chk("R5 no cmd parked", memCmdValid, 1'b0);
      chk("R6 no wb without rsp", wbValid, 1'b0);
    end

    for (int i = 0; i < bpCyc; i++) begin
      @(negedge clk);
      wbReady = 0; memCmdReady = 1'($urandom());
      memRspValid = 1; memRspData = line;
      #1;
      chk("R6 wb offered on rsp", wbValid, 1'b1);
      chk("R6 rsp held under backpressure", memRspReady, 1'b0);
      chk("R5 inReady parked bp", inReady, 1'b0);
    end

    @(negedge clk);
    wbReady = 1; memCmdReady = 1; memRspValid = 1; memRspData = line;
    #1;
    chk("R6 wb valid retire", wbValid, 1'b1);
    chk("R6 rsp consumed", memRspReady, 1'b1);
    chk("R7 load word", wbResult, expWord(line, ofs));
    chk("R9 load opcode", wbOpcode, 4'd4);
    chk("R9 load nextpc", wbNextPc, npc);
    chk("R9 load gen", wbGen, gen);

    @(negedge clk);
    idle();
    setInst(4'd0, 64'd10, 64'd32, 64'd0, 4'd2);
    #1;
    chk("R6 slot freed", inReady, 1'b1);
    chk("R6 waiting add proceeds", wbResult, 64'd42);
    chk("R10 no rsp consume idle", memRspReady, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    memRspValid = 1; memRspData = rndLine();
    #1;
    chk("R1 wbValid reset", wbValid, 1'b0);
    chk("R1 cmdValid reset", memCmdValid, 1'b0);
    chk("R1 rspReady reset", memRspReady, 1'b0);
    chk("R1 inReady reset", inReady, 1'b1);
    chk("R10 stray rsp ignored", memRspReady, 1'b0);

    // directed arithmetic and jumps
    aluOne("R2 add wrap", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h100);
    aluOne("R2 emit", 4'd1, 64'd5, 64'd6, 64'h100);
    aluOne("R2 undefined op", 4'd15, 64'd9, 64'd1, 64'h100);
    aluOne("R3 jz taken", 4'd2, 64'hABC0, 64'd0, 64'h2000);
    aluOne("R3 jz not taken", 4'd2, 64'hABC0, 64'd1, 64'h2000);
    aluOne("R3 jnz taken", 4'd3, 64'hABC0, 64'd1, 64'h2000);
    aluOne("R3 jnz not taken", 4'd3, 64'hABC0, 64'd0, 64'h2000);

    // load refused by memory: not parked
    @(negedge clk);
    idle();
    setInst(4'd4, 64'h1000, 64'h8, 64'h4, 4'd3);
    memCmdReady = 0;
    #1;
    chk("R8 load cmd offered", memCmdValid, 1'b1);
    chk("R8 load not accepted", inReady, 1'b0);
    @(negedge clk);
    idle();
    #1;
    chk("R8 refused load not parked", inReady, 1'b1);

    // load with writeback stalled: no command
    @(negedge clk);
    setInst(4'd4, 64'h1000, 64'h8, 64'h4, 4'd3);
    wbReady = 0;
    #1;
    chk("R8 no cmd when wb stalled", memCmdValid, 1'b0);
    chk("R8 not accepted wb stalled", inReady, 1'b0);

    // directed load offsets
    doLoad(0, 2, 1);
    doLoad(56, 0, 0);
    doLoad(5, 1, 2);

    // random non-load traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  op;
      logic [63:0] a, b, npc;
      logic [3:0]  gen;
      int r;
      logic expV;
      r   = int'($urandom() % 14);
      op  = (r < 4) ? 4'(r) : 4'(r + 1);
      a   = rnd64();
      b   = ($urandom() % 4 == 0) ? 64'd0 : rnd64();
      npc = rnd64();
      gen = 4'($urandom());
      @(negedge clk);
      setInst(op, a, b, npc, gen);
      inValid     = ($urandom() % 4) != 0;
      wbReady     = ($urandom() % 4) != 0;
      memCmdReady = ($urandom() % 4) != 0;
      memRspValid = 1'($urandom());
      #1;
      expV = inValid && memCmdReady;
      chk("R8 inReady", inReady, wbReady && memCmdReady);
      chk("R8 wbValid", wbValid, expV);
      chk("R10 rspReady", memRspReady, 1'b0);
      chk("R4 no cmd for non-load", memCmdValid, 1'b0);
      if (expV) begin
        chk((op == 4'd2 || op == 4'd3) ? "R3 jump result" : "R2 sum result",
            wbResult, expAlu(op, a, b, npc));
        chk("R9 opcode", wbOpcode, op);
        chk("R9 nextpc", wbNextPc, npc);
        chk("R9 gen", wbGen, gen);
      end
    end

    // random aligned loads
    for (int n = 0; n < 60; n++) begin
      doLoad(int'($urandom() % 8) * 8, int'($urandom() % 4), int'($urandom() % 3));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule